// File: doc/BRIEF.md
# Serial EEPROM Target over a Two-Wire Bus

This block is a two-wire (I2C) target that puts a register-file memory behind a small serial-EEPROM command set. The clock and data lines are oversampled by the system clock through a synchronizer. A monitor derives START, STOP and clock-edge events from the synchronized lines. A command engine decodes the device-select byte. It then takes a word address and data bytes for writes, or streams bytes out for reads. The data line is open-drain: the block only ever requests a low level or lets the line go.

Written bytes go to a one-page staging buffer first. They reach the array only after STOP, and only when the write-protect input has been quiet for a window on both sides of that STOP. During writes, the address wraps inside its page. During reads, the address walks the whole array and wraps from the top location back to zero.

Top module: `eep_target`

## Requirements
- R1: After reset the data line is released, every memory location reads 0 (default memory-clear option), and the internal address is 0, so a current-address read returns location 0.
- R2: The target acknowledges a select byte only when its upper seven bits equal binary 1010 followed by `strap_i[2:0]`. The select byte is sent MSB first, and its last bit is the direction (0 = write, 1 = read). For any other select byte the data line stays released on the ninth clock.
- R3: A select byte with direction 0, a word-address byte and one data byte, followed by STOP, stores that byte at that address. A random read (a write select plus a word address, then a repeated START and a read select) returns it.
- R4: Within one write transaction, each data byte advances only the low three bits of the address. Bytes past the end of the 8-byte page wrap to the page's first location, and a later byte replaces an earlier one buffered for the same location.
- R5: A read continues through consecutive addresses for as long as the master acknowledges each byte, and it crosses page boundaries.
- R6: After a read that the master ends with NACK, the address points one past the last byte returned. A following current-address read returns that location.
- R7: During reads the address wraps from 255 to 0.
- R8: The buffered bytes are committed only if `wp_i` is low for at least WP_SETUP synchronized cycles before the detected STOP and through WP_HOLD cycles after it. Otherwise the array is left unchanged.
- R9: The target acknowledges every received byte of an addressed write, including a write that write-protect later blocks. After a master NACK it keeps the data line released.
- R10: A STOP that arrives before all eight bits of a data byte discards that partial byte. The complete bytes before it are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 3 | Hardware address straps, low bits of the device address |
| wp_i | input | 1 | Write-protect input, high blocks commits |
| sda_drive_low_o | output | 1 | High requests that the pin pull the data line low |

## Verification
A STOP that ends a write can fall in the same cycle as the point where a data byte would otherwise have entered the page buffer. In that cycle the monitor both closes the transaction and starts the write-protect hold window. The bench provokes this by sending a STOP after only three bits of a data byte. It judges the result by reading the page back: the two complete bytes must be present and the next location unchanged. A second overlap is a write-protect glitch placed just inside the setup window or the hold window around STOP. Both must leave the array untouched, while an otherwise identical write with a quiet write-protect input commits.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RX_DEV,
      ST_ACK_DEV,
      ST_RX_WADDR,
      ST_ACK_WADDR,
      ST_RX_DATA,
      ST_ACK_DATA,
      ST_TX_DATA,
      ST_TX_ACK,
      ST_WAIT
   } eep_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } eep_bus_ev_t;

endpackage

// File: rtl/eep_bus_monitor.sv
module eep_bus_monitor #(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic               wp_i,
   output eep_pkg::eep_bus_ev_t ev_o,
   output logic               scl_o,
   output logic               wp_o
);

   logic scl_s, sda_s, wp_s;
   logic scl_p, sda_p;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_s <= 1'b1;
               sda_s <= 1'b1;
               wp_s  <= 1'b0;
            end else begin
               scl_s <= scl_i;
               sda_s <= sda_i;
               wp_s  <= wp_i;
            end
         end
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] scl_q, sda_q, wp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
               wp_q  <= '0;
            end else begin
               scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
               sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
               wp_q  <= {wp_q[SYNC_STAGES-2:0], wp_i};
            end
         end
         assign scl_s = scl_q[SYNC_STAGES-1];
         assign sda_s = sda_q[SYNC_STAGES-1];
         assign wp_s  = wp_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      ev_o.start = scl_s & scl_p & sda_p & ~sda_s;
      ev_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
      ev_o.rise  = scl_s & ~scl_p;
      ev_o.fall  = ~scl_s & scl_p;
      ev_o.sda   = sda_s;
   end

   assign scl_o = scl_s;
   assign wp_o  = wp_s;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PAGE_BYTES = 8,
   parameter int PW         = 5,
   localparam int OW        = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    wr_i,
   input  logic [PW-1:0]           wr_page_i,
   input  logic [OW-1:0]           wr_off_i,
   input  logic [7:0]              wr_data_i,
   output logic [PW-1:0]           page_o,
   output logic [PAGE_BYTES*8-1:0] data_o,
   output logic [PAGE_BYTES-1:0]   mask_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
         data_o <= '0;
         mask_o <= '0;
      end else if (clr_i) begin
         mask_o <= '0;
      end else if (wr_i) begin
         page_o <= wr_page_i;
         for (int b = 0; b < PAGE_BYTES; b++) begin
            if (wr_off_i == OW'(b)) begin
               mask_o[b]          <= 1'b1;
               data_o[b*8 +: 8]   <= wr_data_i;
            end
         end
      end
   end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int DEPTH       = 256,
   parameter int PAGE_BYTES  = 8,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int AW         = $clog2(DEPTH),
   localparam int OW         = $clog2(PAGE_BYTES),
   localparam int PW         = AW - OW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           rd_addr_i,
   output logic [7:0]              rd_data_o,
   input  logic                    pg_we_i,
   input  logic [PW-1:0]           pg_idx_i,
   input  logic [PAGE_BYTES*8-1:0] pg_data_i,
   input  logic [PAGE_BYTES-1:0]   pg_mask_i
);

   logic [7:0] mem [DEPTH];

   generate
      if (RESET_CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int a = 0; a < DEPTH; a++) mem[a] <= 8'h00;
            end else if (pg_we_i) begin
               for (int b = 0; b < PAGE_BYTES; b++) begin
                  if (pg_mask_i[b]) mem[{pg_idx_i, OW'(b)}] <= pg_data_i[b*8 +: 8];
               end
            end
         end
      end else begin : g_noclear
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (pg_we_i) begin
               for (int b = 0; b < PAGE_BYTES; b++) begin
                  if (pg_mask_i[b]) mem[{pg_idx_i, OW'(b)}] <= pg_data_i[b*8 +: 8];
               end
            end
         end
      end
   endgenerate

   assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/eep_target.sv
module eep_target #(
   parameter logic [3:0] DEV_NIBBLE      = 4'b1010,
   parameter int         MEM_DEPTH       = 256,
   parameter int         PAGE_BYTES      = 8,
   parameter int         SYNC_STAGES     = 2,
   parameter int         WP_SETUP        = 4,
   parameter int         WP_HOLD         = 4,
   parameter bit         MEM_RESET_CLEAR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       sda_drive_low_o
);
   import eep_pkg::*;

   localparam int AW = $clog2(MEM_DEPTH);
   localparam int OW = $clog2(PAGE_BYTES);
   localparam int PW = AW - OW;
   localparam int SW = $clog2(WP_SETUP + 1);
   localparam int HW = $clog2(WP_HOLD + 1);
   localparam logic [AW-1:0] A_ONE = 1;
   localparam logic [OW-1:0] O_ONE = 1;

   generate
      if (MEM_DEPTH != (1 << AW) || AW > 8) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two no larger than 256");
      end
      if (PAGE_BYTES < 2 || PAGE_BYTES != (1 << OW) || PW < 1) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two, at least 2, below MEM_DEPTH");
      end
      if (WP_SETUP < 1 || WP_HOLD < 1) begin : g_bad_wp
         $error("write-protect windows must be at least one cycle");
      end
   endgenerate

   eep_bus_ev_t bus_ev;
   logic        scl_s, wp_s;

   eep_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .wp_i  (wp_i),
      .ev_o  (bus_ev),
      .scl_o (scl_s),
      .wp_o  (wp_s)
   );

   eep_state_e             state_q;
   logic [3:0]             bitcnt_q;
   logic [7:0]             shreg_q;
   logic [AW-1:0]          addr_q;
   logic                   rw_q, mack_q, drive_q;
   logic [7:0]             rd_data;
   logic [PW-1:0]          buf_page;
   logic [PAGE_BYTES*8-1:0] buf_data;
   logic [PAGE_BYTES-1:0]  buf_mask;
   logic                   pend_q, wp_bad_q, wp_p_q;
   logic [HW-1:0]          hold_q;
   logic [SW-1:0]          stab_q;

   logic byte_done, dev_match, buf_wr, buf_clr, commit_end, commit_we;

   assign byte_done  = bus_ev.fall && (bitcnt_q == 4'd8);
   assign dev_match  = (shreg_q[7:1] == {DEV_NIBBLE, strap_i});
   assign buf_wr     = (state_q == ST_RX_DATA) && byte_done;
   assign commit_end = pend_q && (hold_q == HW'(WP_HOLD - 1));
   assign commit_we  = commit_end && !wp_bad_q && !wp_s;
   assign buf_clr    = ((state_q == ST_RX_WADDR) && byte_done) || commit_end;

   eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (buf_clr),
      .wr_i      (buf_wr),
      .wr_page_i (addr_q[AW-1:OW]),
      .wr_off_i  (addr_q[OW-1:0]),
      .wr_data_i (shreg_q),
      .page_o    (buf_page),
      .data_o    (buf_data),
      .mask_o    (buf_mask)
   );

   eep_array #(.DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES), .RESET_CLEAR(MEM_RESET_CLEAR)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr_i (addr_q),
      .rd_data_o (rd_data),
      .pg_we_i   (commit_we),
      .pg_idx_i  (buf_page),
      .pg_data_i (buf_data),
      .pg_mask_i (buf_mask)
   );

   // command engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         addr_q   <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         drive_q  <= 1'b0;
      end else if (bus_ev.stop) begin
         state_q <= ST_IDLE;
         drive_q <= 1'b0;
      end else if (bus_ev.start) begin
         state_q  <= ST_RX_DEV;
         bitcnt_q <= '0;
         drive_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RX_DEV, ST_RX_WADDR, ST_RX_DATA: begin
               if (bus_ev.rise && bitcnt_q != 4'd8) begin
                  shreg_q  <= {shreg_q[6:0], bus_ev.sda};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end else if (byte_done) begin
                  bitcnt_q <= '0;
                  if (state_q == ST_RX_DEV) begin
                     if (dev_match) begin
                        state_q <= ST_ACK_DEV;
                        rw_q    <= shreg_q[0];
                        drive_q <= 1'b1;
                     end else begin
                        state_q <= ST_WAIT;
                     end
                  end else if (state_q == ST_RX_WADDR) begin
                     state_q <= ST_ACK_WADDR;
                     addr_q  <= shreg_q[AW-1:0];
                     drive_q <= 1'b1;
                  end else begin
                     state_q <= ST_ACK_DATA;
                     drive_q <= 1'b1;
                  end
               end
            end
            ST_ACK_DEV: begin
               if (bus_ev.fall) begin
                  if (rw_q) begin
                     shreg_q  <= rd_data;
                     drive_q  <= ~rd_data[7];
                     addr_q   <= addr_q + A_ONE;
                     bitcnt_q <= '0;
                     state_q  <= ST_TX_DATA;
                  end else begin
                     drive_q <= 1'b0;
                     state_q <= ST_RX_WADDR;
                  end
               end
            end
            ST_ACK_WADDR: begin
               if (bus_ev.fall) begin
                  drive_q <= 1'b0;
                  state_q <= ST_RX_DATA;
               end
            end
            ST_ACK_DATA: begin
               if (bus_ev.fall) begin
                  drive_q <= 1'b0;
                  addr_q  <= {addr_q[AW-1:OW], addr_q[OW-1:0] + O_ONE};
                  state_q <= ST_RX_DATA;
               end
            end
            ST_TX_DATA: begin
               if (bus_ev.fall) begin
                  if (bitcnt_q == 4'd7) begin
                     drive_q <= 1'b0;
                     state_q <= ST_TX_ACK;
                  end else begin
                     shreg_q  <= {shreg_q[6:0], 1'b0};
                     drive_q  <= ~shreg_q[6];
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (bus_ev.rise) begin
                  mack_q <= ~bus_ev.sda;
               end else if (bus_ev.fall) begin
                  if (mack_q) begin
                     shreg_q  <= rd_data;
                     drive_q  <= ~rd_data[7];
                     addr_q   <= addr_q + A_ONE;
                     bitcnt_q <= '0;
                     state_q  <= ST_TX_DATA;
                  end else begin
                     drive_q <= 1'b0;
                     state_q <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // write-protect windows around STOP
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_p_q   <= 1'b0;
         stab_q   <= '0;
         pend_q   <= 1'b0;
         wp_bad_q <= 1'b0;
         hold_q   <= '0;
      end else begin
         wp_p_q <= wp_s;
         if (wp_s != wp_p_q) stab_q <= '0;
         else if (stab_q != SW'(WP_SETUP)) stab_q <= stab_q + SW'(1);
         if (pend_q) begin
            if (commit_end) pend_q <= 1'b0;
            else hold_q <= hold_q + HW'(1);
            if (wp_s) wp_bad_q <= 1'b1;
         end else if (bus_ev.stop && (buf_mask != '0)) begin
            pend_q   <= 1'b1;
            hold_q   <= '0;
            wp_bad_q <= wp_s || (stab_q != SW'(WP_SETUP));
         end
      end
   end

   assign sda_drive_low_o = drive_q;

endmodule

// File: rtl/eep_target_chk.sv
module eep_target_chk #(
   parameter int AW = 8,
   parameter int OW = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                drive_i,
   input eep_pkg::eep_state_e state_i,
   input logic                fall_i,
   input logic                stop_i,
   input logic                mack_i,
   input logic [AW-1:0]       addr_i,
   input logic                commit_i,
   input logic                wp_s_i
);
   import eep_pkg::*;

   localparam logic [AW-1:0] A1 = 1;
   localparam logic [OW-1:0] O1 = 1;

   // R1: the line is let go once STOP is seen
   a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !drive_i);

   // R9: after a NACK or a foreign select nothing is driven
   a_r9_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_WAIT) |-> !drive_i);

   // R4: a write step keeps the page and moves the offset by one, wrapping
   a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_ACK_DATA && fall_i) |=>
         (addr_i[AW-1:OW] == $past(addr_i[AW-1:OW])) &&
         (addr_i[OW-1:0] == $past(addr_i[OW-1:0]) + O1));

   // R7: an acknowledged read step advances the full address, wrapping at the top
   a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_TX_ACK && fall_i && mack_i) |=> (addr_i == $past(addr_i) + A1));

   // R8: a commit only happens with write-protect low now and a cycle earlier
   a_r8_commit_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (!wp_s_i && $past(!wp_s_i)));

endmodule

bind eep_target eep_target_chk #(.AW(AW), .OW(OW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .drive_i  (sda_drive_low_o),
   .state_i  (state_q),
   .fall_i   (bus_ev.fall),
   .stop_i   (bus_ev.stop),
   .mack_i   (mack_q),
   .addr_i   (addr_q),
   .commit_i (commit_we),
   .wp_s_i   (wp_s)
);

// File: tb/eep_target_test.sv
module eep_target_test;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       wp = 1'b0;
   logic [2:0] strap = 3'd5;
   logic       drv;
   logic       bus;

   assign bus = sda_m & ~drv;

   eep_target uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (bus),
      .strap_i         (strap),
      .wp_i            (wp),
      .sda_drive_low_o (drv)
   );

   always #10 clk = ~clk;

   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;
   logic [7:0] model [256];
   logic [7:0] wbuf [16];

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tickn(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [6:0] dev();
      return {4'b1010, strap};
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic bus_start();
      tickn(1); sda_m = 1'b1; tickn(HALF); scl = 1'b1; tickn(HALF);
      sda_m = 1'b0; tickn(HALF); scl = 1'b0;
   endtask

   // wpmode 0: quiet, 1: glitch inside setup window, 2: glitch inside hold window
   task automatic bus_stop(input int wpmode);
      tickn(1); sda_m = 1'b0; tickn(HALF); scl = 1'b1;
      if (wpmode == 1) begin
         tickn(HALF - 3); wp = 1'b1; tickn(1); wp = 1'b0; tickn(2);
      end else begin
         tickn(HALF);
      end
      sda_m = 1'b1;
      if (wpmode == 2) begin
         tickn(1); wp = 1'b1; tickn(1); wp = 1'b0; tickn(HALF - 2);
      end else begin
         tickn(HALF);
      end
   endtask

   task automatic wbit(input logic b);
      tickn(1); sda_m = b; tickn(HALF - 1); scl = 1'b1; tickn(HALF); scl = 1'b0;
   endtask

   task automatic rbit(output logic b);
      tickn(1); sda_m = 1'b1; tickn(HALF - 1); scl = 1'b1; tickn(HALF / 2);
      b = bus; tickn(HALF / 2); scl = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] d, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = (b == 1'b0);
   endtask

   task automatic rbyte(input bit give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      wbit(give_ack ? 1'b0 : 1'b1);
   endtask

   // start, write select, word address, n bytes from wbuf; no STOP
   task automatic write_run(input logic [7:0] a, input int n, output bit all_ack);
      bit ack;
      bus_start();
      wbyte({dev(), 1'b0}, ack); all_ack = ack;
      wbyte(a, ack); all_ack &= ack;
      for (int i = 0; i < n; i++) begin
         wbyte(wbuf[i], ack);
         all_ack &= ack;
      end
   endtask

   // random read of n bytes from a, compared with the model
   task automatic read_check(input logic [7:0] a, input int n, input string tag);
      bit ack;
      logic [7:0] d;
      bus_start();
      wbyte({dev(), 1'b0}, ack);
      wbyte(a, ack);
      bus_start();
      wbyte({dev(), 1'b1}, ack);
      for (int i = 0; i < n; i++) begin
         rbyte(i != n - 1, d);
         chk(tag, d, model[8'(int'(a) + i)]);
      end
      chk("R9 released after master NACK", bus, 1'b1);
      bus_stop(0);
   endtask

   task automatic cur_read(output logic [7:0] d);
      bit ack;
      bus_start();
      wbyte({dev(), 1'b1}, ack);
      rbyte(1'b0, d);
      bus_stop(0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] d;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      tickn(3);
      chk("R1 line released in reset", drv, 1'b0);
      rst_n = 1'b1;
      tickn(5);
      chk("R1 line released after reset", drv, 1'b0);

      // R1: current-address read from reset returns location 0 (cleared)
      cur_read(d);
      chk("R1 reset address and contents", d, 8'h00);

      // R2: sweep straps and select low bits
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         for (int a = 0; a < 8; a++) begin
            bus_start();
            wbyte({4'b1010, 3'(a), 1'b0}, ack);
            bus_stop(0);
            chk("R2 select match", ack, a == s);
         end
      end
      strap = 3'd5;
      bus_start();
      wbyte({4'b0101, strap, 1'b0}, ack);
      bus_stop(0);
      chk("R2 foreign upper nibble ignored", ack, 1'b0);

      // R3: byte write then random read
      wbuf[0] = 8'h5A;
      write_run(8'h10, 1, ack);
      bus_stop(0);
      chk("R9 byte write acked", ack, 1'b1);
      model[8'h10] = 8'h5A;
      read_check(8'h10, 1, "R3 byte write readback");

      // full page sweep, every page a computed pattern
      for (int p = 0; p < 32; p++) begin
         for (int i = 0; i < 8; i++) wbuf[i] = pat(p * 8 + i);
         write_run(8'(p * 8), 8, ack);
         bus_stop(0);
         chk("R9 page write acked", ack, 1'b1);
         for (int i = 0; i < 8; i++) model[p * 8 + i] = pat(p * 8 + i);
      end
      read_check(8'h00, 256, "R5 sequential read of whole array");

      // R7 wrap and R6 next address
      read_check(8'hFE, 4, "R7 read wraps 255 to 0");
      cur_read(d);
      chk("R6 address one past last byte read", d, model[8'h02]);

      // R4: eleven bytes from offset 3 of page 0x20
      for (int i = 0; i < 11; i++) wbuf[i] = 8'(8'hC0 + i);
      write_run(8'h23, 11, ack);
      bus_stop(0);
      chk("R9 wrapping write acked", ack, 1'b1);
      for (int i = 0; i < 11; i++) model[8'h20 + ((3 + i) % 8)] = 8'(8'hC0 + i);
      read_check(8'h20, 9, "R4 page wrap and overwrite");

      // R8: write-protect held, setup glitch, hold glitch
      wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
      wp = 1'b1;
      tickn(10);
      write_run(8'h48, 2, ack);
      bus_stop(0);
      chk("R9 protected write still acked", ack, 1'b1);
      tickn(10);
      wp = 1'b0;
      tickn(10);
      read_check(8'h48, 2, "R8 held protect leaves array");

      write_run(8'h48, 2, ack);
      bus_stop(1);
      chk("R9 setup-glitch write acked", ack, 1'b1);
      read_check(8'h48, 2, "R8 glitch before stop blocks");

      write_run(8'h48, 2, ack);
      bus_stop(2);
      chk("R9 hold-glitch write acked", ack, 1'b1);
      read_check(8'h48, 2, "R8 glitch after stop blocks");

      write_run(8'h48, 2, ack);
      bus_stop(0);
      model[8'h48] = 8'hE1; model[8'h49] = 8'hE2;
      read_check(8'h48, 2, "R8 quiet protect commits");

      // R10: two full bytes then three bits, then STOP
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      write_run(8'h60, 2, ack);
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      bus_stop(0);
      model[8'h60] = 8'h11; model[8'h61] = 8'h22;
      read_check(8'h60, 3, "R10 partial byte discarded");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule